// File: doc/BRIEF.md
# Fetch-Path Bit-Set Fault Injector

This block sits on the read return path between an instruction or data memory and whatever consumes the fetched words. Normally it is transparent: every word and its valid flag go through untouched, in the same cycle. When armed, it models a deterministic, single-shot optical fault on that path. Some number of whole clock cycles after an external trigger rises, the next valid fetch comes back with one chosen bit, or a pair of neighbouring bits, forced to 1. Nothing is ever written back, so a later fetch of the same location returns the true contents.

Software or a test harness pulses `cfg_arm` together with a target bit index, a pair-mode flag and a cycle delay. These values are captured on that pulse. The trigger input is edge sensitive. The bit that is actually hit depends on where the fetched word sits in memory: a word on a 4-byte boundary takes the programmed index as it is, and a fetch whose address is only halfword aligned has the index moved by half a word. After the fault has been applied once, the block stays transparent until it is armed again. A one-cycle pulse marks the corrupted fetch, and a sticky flag records that the shot was spent.

Top module: `fetch_bitset_injector`

## Requirements
- R1: While reset is asserted and just after it is released, `out_data` equals `rd_data`, `out_valid` equals `rd_valid`, and both `fault_hit` and `fault_fired` are 0. A trigger that arrives before any `cfg_arm` has no effect.
- R2: In every cycle where no fault is applied, `out_data` equals `rd_data` bit for bit. `out_valid` always equals `rd_valid`, in the same cycle.
- R3: A fault can only turn returned bits from 0 to 1. A bit that `rd_data` presents as 1 reads 1 on `out_data`, including when the word is all ones.
- R4: With `cfg_dual`=0 captured at arm time, the corrupted word equals `rd_data` OR a mask that has exactly one bit set, at position p.
- R5: With `cfg_dual`=1, the mask has bits p and (p+1) mod 32 set, so p=31 pairs with bit 0. No other pattern is produced.
- R6: The position p depends on bit 1 of `rd_addr`. If `rd_addr[1]`=0 (4-byte aligned), p equals the captured `cfg_bit`. If `rd_addr[1]`=1 (halfword aligned), p = (`cfg_bit`+16) mod 32.
- R7: Let c be the first cycle in which `trig_in` is sampled high after being low, while the block is armed, and let D be the captured `cfg_delay`. The fault window opens in cycle c+D+1. The fault is applied to the first fetch with `rd_valid`=1 in that cycle or any later one. Fetches before the window opens pass unchanged.
- R8: The fault is applied at most once per arming. Afterwards every fetch, including a repeat of the same word at the same address, passes unchanged until the next `cfg_arm`.
- R9: Trigger edges that arrive while a delay is counting, while the window is open, or after the shot is spent are ignored. They neither restart nor move the window.
- R10: `fault_hit` is 1 only in the cycle in which a fetch is corrupted. `fault_fired` becomes 1 in the cycle after that and stays 1.
- R11: `cfg_arm` captures the configuration, cancels any pending countdown or window, and clears `fault_fired` from the next cycle on. A trigger edge sampled in the same cycle as `cfg_arm` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fetch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arm | input | 1 | One-cycle pulse: capture configuration and arm |
| cfg_bit | input | 5 | Target bit index for an aligned fetch |
| cfg_dual | input | 1 | 1 = also set the next higher bit (wrapping) |
| cfg_delay | input | 8 | Whole cycles between the trigger and the window opening |
| trig_in | input | 1 | External trigger, rising-edge sensitive |
| rd_valid | input | 1 | Read data from memory is valid this cycle |
| rd_addr | input | 32 | Byte address of the fetch being returned |
| rd_data | input | 32 | Word read from memory |
| out_valid | output | 1 | Valid toward the consumer |
| out_data | output | 32 | Word toward the consumer, possibly corrupted |
| fault_hit | output | 1 | High in the cycle a fetch is corrupted |
| fault_fired | output | 1 | Sticky: the armed shot has been used |

## Verification
Some properties hold in every cycle, and the bound checker tests those continuously. These are the set-only rule, exact pass-through whenever no hit is flagged, a limit of two changed bits on a hit, a hit only on a valid fetch, the single-cycle hit pulse, the sticky flag following a hit, re-arm clearing that flag, and no hit once the shot is spent. Other properties can only be shown by the bench's scenarios, because they depend on how cycles are counted and on the captured configuration. These are the exact cycle in which the window opens relative to the trigger edge, the choice of bit under both alignments, the wrap of the pair from the top bit to bit 0, and the discarding of repeated triggers and of a trigger that coincides with arming.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

   // Sequencer states of the one-shot injector.
   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_ARMED  = 3'd1,
      SQ_COUNT  = 3'd2,
      SQ_WINDOW = 3'd3,
      SQ_SPENT  = 3'd4
   } sq_state_e;

   // Bit position of the address that tells a halfword-only fetch apart
   // from a full-word aligned one, for a word of the given width.
   function automatic int unsigned half_addr_bit(input int unsigned data_w);
      return $clog2(data_w / 8) - 1;
   endfunction

endpackage

// File: rtl/fbi_edge.sv
module fbi_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= ~RISING;
      else        prev_q <= level_i;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse_o = level_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = ~level_i & prev_q;
      end
   endgenerate

endmodule

// File: rtl/fbi_sequencer.sv
module fbi_sequencer
   import fbi_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             start_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic             fetch_i,
   output logic             window_o,
   output logic             fired_o
);

   localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
   localparam logic [DLY_W-1:0] CNT_ZERO = '0;

   sq_state_e        state_q;
   logic [DLY_W-1:0] cnt_q;
   logic             fired_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= CNT_ZERO;
         fired_q <= 1'b0;
      end else if (arm_i) begin
         state_q <= SQ_ARMED;
         cnt_q   <= CNT_ZERO;
         fired_q <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_ARMED: begin
               if (start_i) begin
                  if (delay_i == CNT_ZERO) begin
                     state_q <= SQ_WINDOW;
                  end else begin
                     state_q <= SQ_COUNT;
                     cnt_q   <= delay_i;
                  end
               end
            end
            SQ_COUNT: begin
               cnt_q <= cnt_q - CNT_ONE;
               if (cnt_q == CNT_ONE) state_q <= SQ_WINDOW;
            end
            SQ_WINDOW: begin
               if (fetch_i) begin
                  state_q <= SQ_SPENT;
                  fired_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign window_o = (state_q == SQ_WINDOW);
   assign fired_o  = fired_q;

endmodule

// File: rtl/fbi_mask.sv
module fbi_mask #(
   parameter int DATA_W     = 32,
   parameter bit HALF_REMAP = 1'b1,
   localparam int IDX_W     = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              dual_i,
   input  logic              half_i,
   output logic [DATA_W-1:0] mask_o
);

   localparam logic [IDX_W-1:0] HALF_OFS = IDX_W'(DATA_W / 2);

   logic [IDX_W-1:0] pos;

   generate
      if (HALF_REMAP) begin : g_remap
         // Modulo DATA_W comes for free from the IDX_W-bit wrap.
         assign pos = idx_i + (half_i ? HALF_OFS : '0);
      end else begin : g_fixed
         logic unused_half;
         assign unused_half = half_i;
         assign pos = idx_i;
      end
   endgenerate

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         localparam logic [IDX_W-1:0] SELF  = IDX_W'(b);
         localparam logic [IDX_W-1:0] BELOW = IDX_W'((b + DATA_W - 1) % DATA_W);
         assign mask_o[b] = (pos == SELF) | (dual_i & (pos == BELOW));
      end
   endgenerate

endmodule

// File: rtl/fetch_bitset_injector.sv
module fetch_bitset_injector
   import fbi_pkg::*;
#(
   parameter int  DATA_W      = 32,
   parameter int  ADDR_W      = 32,
   parameter int  DLY_W       = 8,
   parameter bit  HALF_REMAP  = 1'b1,
   parameter bit  TRIG_RISING = 1'b1,
   localparam int IDX_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_arm,
   input  logic [IDX_W-1:0]  cfg_bit,
   input  logic              cfg_dual,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic              trig_in,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              fault_hit,
   output logic              fault_fired
);

   localparam int HALF_BIT = half_addr_bit(DATA_W);

   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("fetch_bitset_injector: DATA_W must be a power of two of at least 16");
      end
      if (ADDR_W <= HALF_BIT) begin : g_bad_addr
         $error("fetch_bitset_injector: ADDR_W too narrow to carry the halfword bit");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("fetch_bitset_injector: DLY_W must be at least 1");
      end
   endgenerate

   // Configuration captured on arm.
   logic [IDX_W-1:0] bit_q;
   logic             dual_q;
   logic [DLY_W-1:0] delay_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q   <= '0;
         dual_q  <= 1'b0;
         delay_q <= '0;
      end else if (cfg_arm) begin
         bit_q   <= cfg_bit;
         dual_q  <= cfg_dual;
         delay_q <= cfg_delay;
      end
   end

   logic trig_pulse;
   logic window;
   logic [DATA_W-1:0] mask;
   logic hit;

   fbi_edge #(
      .RISING (TRIG_RISING)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (trig_in),
      .pulse_o (trig_pulse)
   );

   fbi_sequencer #(
      .DLY_W (DLY_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (cfg_arm),
      .start_i  (trig_pulse),
      .delay_i  (delay_q),
      .fetch_i  (rd_valid),
      .window_o (window),
      .fired_o  (fault_fired)
   );

   fbi_mask #(
      .DATA_W     (DATA_W),
      .HALF_REMAP (HALF_REMAP)
   ) u_mask (
      .idx_i  (bit_q),
      .dual_i (dual_q),
      .half_i (rd_addr[HALF_BIT]),
      .mask_o (mask)
   );

   logic unused_addr;
   assign unused_addr = ^rd_addr;

   assign hit       = window & rd_valid;
   assign fault_hit = hit;
   assign out_valid = rd_valid;
   assign out_data  = rd_data | (hit ? mask : '0);

endmodule

// File: rtl/fbi_checker.sv
module fbi_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_arm,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              fault_hit,
   input logic              fault_fired
);

   AST_PASS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_hit |-> out_data == rd_data);                        // R2

   AST_VALID_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == rd_valid);                                     // R2

   AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_data & rd_data) == rd_data);                           // R3

   AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      fault_hit |-> $countones(out_data ^ rd_data) <= 2);         // R5

   AST_HIT_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fault_hit |-> rd_valid);                                    // R7

   AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fault_fired |-> !fault_hit);                                // R8

   AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_hit |=> !fault_hit);                                  // R10

   AST_FIRED_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_hit && !cfg_arm) |=> fault_fired);                   // R10

   AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_arm |=> !fault_fired);                                  // R11

endmodule

bind fetch_bitset_injector fbi_checker #(
   .DATA_W (DATA_W)
) u_fbi_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_arm     (cfg_arm),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .fault_hit   (fault_hit),
   .fault_fired (fault_fired)
);

// File: tb/fetch_bitset_injector_test.sv
`timescale 1ns/1ps
module fetch_bitset_injector_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_arm = 1'b0;
   logic [4:0]  cfg_bit = '0;
   logic        cfg_dual = 1'b0;
   logic [7:0]  cfg_delay = '0;
   logic        trig_in = 1'b0;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_addr = '0;
   logic [31:0] rd_data = '0;
   logic        out_valid;
   logic [31:0] out_data;
   logic        fault_hit;
   logic        fault_fired;

   always #2.5 clk = ~clk;

   fetch_bitset_injector uut (
      .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_bit(cfg_bit),
      .cfg_dual(cfg_dual), .cfg_delay(cfg_delay), .trig_in(trig_in),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
      .out_valid(out_valid), .out_data(out_data),
      .fault_hit(fault_hit), .fault_fired(fault_fired)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int unsigned cyc = 0;

   // Reference model state, derived from the requirements.
   bit          m_armed = 0, m_pend = 0, m_fired = 0, m_prev = 0;
   int unsigned m_open = 0;
   int          m_bit = 0;
   bit          m_dual = 0;

   function automatic logic [31:0] exp_mask(int n, bit dual, bit half);
      int p;
      logic [31:0] m;
      p = half ? (n + 16) % 32 : n;                       // R6
      m = 32'h1 << p;                                     // R4
      if (dual) m = m | (32'h1 << ((p + 1) % 32));        // R5
      return m;
   endfunction

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
   endtask

   task automatic step(input bit arm, input int nb, input bit dual, input int dly,
                       input bit trig, input bit valid, input logic [31:0] addr,
                       input logic [31:0] data, input string tag);
      bit          e_hit, rise;
      logic [31:0] e_out;
      @(posedge clk);
      #1;
      cfg_arm = arm; cfg_bit = 5'(nb); cfg_dual = dual; cfg_delay = 8'(dly);
      trig_in = trig; rd_valid = valid; rd_addr = addr; rd_data = data;
      e_hit = m_pend && (cyc >= m_open) && valid;          // R7
      e_out = e_hit ? (data | exp_mask(m_bit, m_dual, addr[1])) : data;
      @(negedge clk);
      n_checks++;
      if (out_data !== e_out || fault_hit !== e_hit || fault_fired !== m_fired
          || out_valid !== valid) begin
         n_fail++;
         $display("FAIL %s cyc %0d: out=%h hit=%b fired=%b vld=%b expected out=%h hit=%b fired=%b vld=%b",
                  tag, cyc, out_data, fault_hit, fault_fired, out_valid,
                  e_out, e_hit, m_fired, valid);
      end
      rise = trig && !m_prev;
      m_prev = trig;
      if (arm) begin                                      // R11
         m_bit = nb; m_dual = dual; m_armed = 1; m_pend = 0; m_fired = 0;
         m_open = dly;
      end else if (e_hit) begin                           // R8
         m_pend = 0; m_fired = 1;
      end else if (m_armed && rise) begin                 // R9: only when armed
         m_armed = 0; m_pend = 1; m_open = cyc + m_open + 1;
      end
      cyc++;
   endtask

   function automatic logic [31:0] pick_addr(int amode);
      logic [31:0] a;
      a = $urandom;
      a[0] = 1'b0;
      if (amode == 0) a[1] = 1'b0;
      else if (amode == 1) a[1] = 1'b1;
      return a;
   endfunction

   function automatic logic [31:0] pick_data(int dmode);
      if (dmode == 1) return 32'hFFFF_FFFF;
      if (dmode == 2) return 32'h0;
      return $urandom;
   endfunction

   // One arm / trigger / fetch sequence.
   task automatic shot(int nb, bit dual, int dly, int amode, int dmode, int vpct,
                       int tlen, int retrig, string tag);
      bit v;
      step(1, nb, dual, dly, 0, 1'b1, pick_addr(amode), pick_data(dmode), tag);
      repeat (2) step(0, 0, 0, 0, 0, 1'b1, pick_addr(amode), pick_data(dmode), tag);
      for (int k = 0; k < dly + 14; k++) begin
         v = ($urandom % 100) < vpct;
         step(0, 0, 0, 0, (k < tlen) || (k == retrig), v, pick_addr(amode),
              pick_data(dmode), tag);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
      $finish;
   end

   initial begin
      logic [31:0] w;
      void'($urandom(32'd1234));
      rd_valid = 1'b1; rd_data = 32'h1234_5678; trig_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (out_data !== 32'h1234_5678 || fault_hit !== 1'b0 || fault_fired !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 in reset: out=%h hit=%b fired=%b expected out=12345678 hit=0 fired=0",
                  out_data, fault_hit, fault_fired);
      end
      @(posedge clk); #1 rst_n = 1'b1;

      // R1: trigger before any arm has no effect.
      for (int k = 0; k < 10; k++)
         step(0, 0, 0, 0, k[1], 1'b1, pick_addr(2), pick_data(2), "R1");

      // R4/R7: single bit, aligned, delay 3.
      shot(5, 0, 3, 0, 2, 100, 1, -1, "R4");
      // R6: same index, halfword fetch -> bit 21.
      shot(5, 0, 3, 1, 2, 100, 1, -1, "R6");
      // R5: pair wrap at top bit, aligned -> bits 31 and 0.
      shot(31, 1, 2, 0, 2, 100, 1, -1, "R5");
      // R5: index 15 halfword -> bits 31 and 0.
      shot(15, 1, 2, 1, 2, 100, 2, -1, "R5");
      // R6: index 31 halfword -> bits 15 and 16.
      shot(31, 1, 4, 1, 2, 100, 1, -1, "R6");
      // R7: zero delay, window next cycle.
      shot(0, 0, 0, 0, 2, 100, 1, -1, "R7");
      // R7: sparse fetches, fault lands on first valid one.
      shot(9, 0, 5, 2, 0, 20, 1, -1, "R7");
      // R9: second edge during countdown ignored.
      shot(12, 0, 8, 0, 0, 100, 1, 3, "R9");
      // R3: all-ones word is unchanged by a hit.
      shot(7, 1, 2, 2, 1, 100, 1, -1, "R3");

      // R8: same word, same address, refetched after the shot.
      step(1, 3, 0, 1, 0, 1'b0, 32'h0, 32'h0, "R8");
      step(0, 0, 0, 0, 1, 1'b0, 32'h0, 32'h0, "R8");
      for (int k = 0; k < 8; k++)
         step(0, 0, 0, 0, k[0], 1'b1, 32'h100, 32'h0, "R8");

      // R11: re-arm during countdown cancels the first shot.
      step(1, 3, 0, 10, 0, 1'b1, 32'h0, 32'h0, "R11");
      step(0, 0, 0, 0, 1, 1'b1, 32'h0, 32'h0, "R11");
      repeat (3) step(0, 0, 0, 0, 0, 1'b1, 32'h0, 32'h0, "R11");
      step(1, 9, 0, 2, 0, 1'b1, 32'h0, 32'h0, "R11");
      repeat (12) step(0, 0, 0, 0, 0, 1'b1, 32'h0, 32'h0, "R11");
      step(0, 0, 0, 0, 1, 1'b1, 32'h0, 32'h0, "R11");
      repeat (6) step(0, 0, 0, 0, 0, 1'b1, 32'h0, 32'h0, "R11");

      // R11: edge coinciding with arm is discarded; held level does not refire.
      step(1, 20, 0, 1, 1, 1'b1, 32'h0, 32'h0, "R11");
      repeat (6) step(0, 0, 0, 0, 1, 1'b1, 32'h0, 32'h0, "R11");
      step(0, 0, 0, 0, 0, 1'b1, 32'h0, 32'h0, "R11");
      step(0, 0, 0, 0, 1, 1'b1, 32'h0, 32'h0, "R11");
      repeat (5) step(0, 0, 0, 0, 0, 1'b1, 32'h0, 32'h0, "R10");

      // R2/R10: random mix.
      for (int s = 0; s < 150; s++) begin
         w = $urandom;
         shot(int'(w[4:0]), w[5], int'(w[10:6] % 21), 2, int'(w[12:11] % 3),
              30 + int'(w[18:13] % 71), 1 + int'(w[20:19]),
              w[21] ? int'(w[25:22]) : -1, "R2");
      end

      report();
      $finish;
   end

endmodule